// File: doc/BRIEF.md
# Round-Robin Shared Pipelined Unit Arbiter

This block lets a group of thread processors share one pipelined execution unit. Any thread may raise a request that carries two operands and a destination tag. In each cycle the block grants at most one request. Priority rotates among the threads, so no thread is shut out.

The granted operation enters a pipeline with a fixed depth. The unit takes a new operation every cycle. After the configured latency the unit presents the result together with the index of the granted thread and the tag of that thread, so the right register file can be written.

The datapath here is an unsigned integer multiplier. Its only purpose is to exercise the arbitration and the steering of results. The number of threads, the latency and the operand and tag widths are parameters. A thread that loses arbitration holds its request and tries again in the next cycle.

Top module: `shared_fu_arbiter`

## Requirements
- R1: After reset the priority pointer is at thread 0, `resValid` is 0 and no result is pending.
- R2: `grant` is a one-hot or all-zero vector, and it is combinational from `reqValid` in the same cycle. A bit is set only when the matching request bit is set.
- R3: The grant goes to the first requesting thread found by searching upward from the priority pointer and wrapping from thread NUM_THREADS-1 to thread 0.
- R4: After a grant to thread i, the pointer moves to i+1, wrapping to 0 after NUM_THREADS-1. In a cycle with no requests the pointer does not change.
- R5: An operation granted in cycle c shows `resValid`=1 in cycle c+LATENCY. `resData` then equals the unsigned product opA*opB, RES_W = 2*DATA_W bits wide.
- R6: A valid result shows, on `resThread`, the index of the thread that was granted. It shows, on `resTag`, the tag that thread sent in its request.
- R7: The unit takes a new operation in every cycle. Back-to-back grants give results in consecutive cycles, in the order they were granted.
- R8: A thread that holds its request is granted within NUM_THREADS cycles. When all threads request for NUM_THREADS cycles in a row, each thread is granted exactly once.
- R9: A cycle with no grant gives `resValid`=0 LATENCY cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_THREADS | Request bit, one per thread |
| reqOpA | input | NUM_THREADS*DATA_W | First operand of each thread; thread t uses bits [t*DATA_W +: DATA_W] |
| reqOpB | input | NUM_THREADS*DATA_W | Second operand of each thread, packed the same way |
| reqTag | input | NUM_THREADS*TAG_W | Destination tag of each thread; thread t uses bits [t*TAG_W +: TAG_W] |
| grant | output | NUM_THREADS | One-hot grant for the current cycle |
| resValid | output | 1 | Result valid |
| resThread | output | IDX_W | Index of the thread the result belongs to |
| resTag | output | TAG_W | Destination tag returned with the result |
| resData | output | 2*DATA_W | Product |

## Verification
The request patterns each test one part of the arbiter:
- A single thread that requests repeatedly shows that the search wraps past the top index back to itself.
- The pair at the two ends (threads 7 and 0) shows that the winner alternates across the wrap point.
- Two adjacent requesters show that the pointer moves past the winner, not just to the next requester.
- Idle cycles between bursts show that the pointer holds its position and that no result appears LATENCY cycles later.

A full-mask burst held for NUM_THREADS cycles shows that every thread is granted exactly once. The result stream is checked against the operands, the index and the tag of each recorded winner, so a result that is misrouted or delayed stands out.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  localparam int IDX_MAX_W = 8;

  // Strobes from the arbiter control to the datapath
  typedef struct packed {
    logic                 launch;
    logic [IDX_MAX_W-1:0] winIdx;
  } sfa_strobe_t;
endpackage

// File: rtl/sfa_ctrl.sv
module sfa_ctrl
  import sfa_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] reqValid,
  output logic [NUM_THREADS-1:0] grant,
  output sfa_strobe_t            strobe
);
  logic [IDX_W-1:0] prioPtr;
  logic             found;
  logic [IDX_W-1:0] winIdx;

  // Search upward from the pointer, wrapping at the top
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      int cand;
      cand = int'(prioPtr) + i;
      if (cand >= NUM_THREADS) cand = cand - NUM_THREADS;
      if (!found && reqValid[cand]) begin
        found  = 1'b1;
        winIdx = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    grant = '0;
    if (found) grant[winIdx] = 1'b1;
    strobe.launch = found;
    strobe.winIdx = IDX_MAX_W'(winIdx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prioPtr <= '0;
    end else if (found) begin
      if (int'(winIdx) == NUM_THREADS - 1) prioPtr <= '0;
      else                                 prioPtr <= winIdx + 1'b1;
    end
  end
endmodule

// File: rtl/sfa_datapath.sv
module sfa_datapath
  import sfa_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int LATENCY     = 2,
  parameter int DATA_W      = 16,
  parameter int TAG_W       = 5,
  localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  sfa_strobe_t                   strobe,
  input  logic [NUM_THREADS*DATA_W-1:0] reqOpA,
  input  logic [NUM_THREADS*DATA_W-1:0] reqOpB,
  input  logic [NUM_THREADS*TAG_W-1:0]  reqTag,
  output logic                          resValid,
  output logic [IDX_W-1:0]              resThread,
  output logic [TAG_W-1:0]              resTag,
  output logic [RES_W-1:0]              resData
);
  logic [IDX_W-1:0]  selIdx;
  logic [DATA_W-1:0] selA, selB;
  logic [TAG_W-1:0]  selTag;

  assign selIdx = IDX_W'(strobe.winIdx);
  assign selA   = reqOpA[selIdx*DATA_W +: DATA_W];
  assign selB   = reqOpB[selIdx*DATA_W +: DATA_W];
  assign selTag = reqTag[selIdx*TAG_W +: TAG_W];

  logic             stValid [LATENCY];
  logic [IDX_W-1:0] stIdx   [LATENCY];
  logic [TAG_W-1:0] stTag   [LATENCY];
  logic [RES_W-1:0] stData  [LATENCY];

  // First stage: operand select and multiply
  always_ff @(posedge clk) begin
    if (!rst_n) stValid[0] <= 1'b0;
    else        stValid[0] <= strobe.launch;
    stIdx[0]  <= selIdx;
    stTag[0]  <= selTag;
    stData[0] <= RES_W'(selA) * RES_W'(selB);
  end

  // Remaining stages only carry the result along
  for (genvar k = 1; k < LATENCY; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stValid[k] <= 1'b0;
      else        stValid[k] <= stValid[k-1];
      stIdx[k]  <= stIdx[k-1];
      stTag[k]  <= stTag[k-1];
      stData[k] <= stData[k-1];
    end
  end

  assign resValid  = stValid[LATENCY-1];
  assign resThread = stIdx[LATENCY-1];
  assign resTag    = stTag[LATENCY-1];
  assign resData   = stData[LATENCY-1];
endmodule

// File: rtl/shared_fu_arbiter.sv
module shared_fu_arbiter
  import sfa_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int LATENCY     = 2,
  parameter int DATA_W      = 16,
  parameter int TAG_W       = 5,
  localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        reqValid,
  input  logic [NUM_THREADS*DATA_W-1:0] reqOpA,
  input  logic [NUM_THREADS*DATA_W-1:0] reqOpB,
  input  logic [NUM_THREADS*TAG_W-1:0]  reqTag,
  output logic [NUM_THREADS-1:0]        grant,
  output logic                          resValid,
  output logic [IDX_W-1:0]              resThread,
  output logic [TAG_W-1:0]              resTag,
  output logic [RES_W-1:0]              resData
);
  sfa_strobe_t strobe;

  sfa_ctrl #(.NUM_THREADS(NUM_THREADS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .grant(grant), .strobe(strobe)
  );

  sfa_datapath #(
    .NUM_THREADS(NUM_THREADS), .LATENCY(LATENCY),
    .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reqOpA(reqOpA), .reqOpB(reqOpB), .reqTag(reqTag),
    .resValid(resValid), .resThread(resThread),
    .resTag(resTag), .resData(resData)
  );
endmodule

// File: rtl/sfa_checker.sv
module sfa_checker #(
  parameter int NUM_THREADS = 8,
  parameter int LATENCY     = 2,
  localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CNT_W = $clog2(NUM_THREADS + 1) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_THREADS-1:0] reqValid,
  input logic [NUM_THREADS-1:0] grant,
  input logic                   resValid,
  input logic [IDX_W-1:0]       resThread
);
  logic             histV [LATENCY];
  logic [IDX_W-1:0] histI [LATENCY];
  logic [IDX_W-1:0] grantIdx;

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_THREADS; i++)
      if (grant[i]) grantIdx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LATENCY; k++) begin
        histV[k] <= 1'b0;
        histI[k] <= '0;
      end
    end else begin
      histV[0] <= |grant;
      histI[0] <= grantIdx;
      for (int k = 1; k < LATENCY; k++) begin
        histV[k] <= histV[k-1];
        histI[k] <= histI[k-1];
      end
    end
  end

  // R2: grant is one-hot or empty
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R2: a grant goes only to a requesting thread
  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~reqValid) == '0);
  // R5, R9: a result appears exactly LATENCY cycles after each grant
  assert_result_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resValid == histV[LATENCY-1]);
  // R6: a result is returned to the thread that was granted
  assert_result_thread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> resThread == histI[LATENCY-1]);

  // R8: wait counters per thread
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_wait
    logic [CNT_W-1:0] waitCnt;
    always_ff @(posedge clk) begin
      if (!rst_n || !reqValid[t] || grant[t]) waitCnt <= '0;
      else                                    waitCnt <= waitCnt + 1'b1;
    end
    assert_no_starve_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(waitCnt) < NUM_THREADS);
  end
endmodule

bind shared_fu_arbiter sfa_checker #(
  .NUM_THREADS(NUM_THREADS), .LATENCY(LATENCY)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .grant(grant),
  .resValid(resValid), .resThread(resThread)
);

// File: tb/shared_fu_arbiter_tb.sv
module shared_fu_arbiter_tb_top;
  localparam int N   = 8;
  localparam int L   = 2;
  localparam int DW  = 16;
  localparam int TW  = 5;
  localparam int IW  = 3;
  localparam int NV  = 14;
  localparam int NONE = 15;

  // {expected winner (15 = none), request mask}
  localparam logic [11:0] VEC [NV] = '{
    {4'd15, 8'h00}, {4'd0, 8'h01}, {4'd0, 8'h01}, {4'd7, 8'h81},
    {4'd0, 8'h81},  {4'd1, 8'hFF}, {4'd2, 8'hFF}, {4'd15, 8'h00},
    {4'd3, 8'h0C},  {4'd2, 8'h0C}, {4'd4, 8'h30}, {4'd5, 8'hFF},
    {4'd6, 8'h41},  {4'd0, 8'h41}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    reqValid = '0;
  logic [N*DW-1:0] reqOpA = '0;
  logic [N*DW-1:0] reqOpB = '0;
  logic [N*TW-1:0] reqTag = '0;
  logic [N-1:0]    grant;
  logic            resValid;
  logic [IW-1:0]   resThread;
  logic [TW-1:0]   resTag;
  logic [2*DW-1:0] resData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shared_fu_arbiter #(.NUM_THREADS(N), .LATENCY(L), .DATA_W(DW), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOpA(reqOpA),
    .reqOpB(reqOpB), .reqTag(reqTag), .grant(grant), .resValid(resValid),
    .resThread(resThread), .resTag(resTag), .resData(resData)
  );

  function automatic logic [DW-1:0] opA(int s, int t);
    return DW'(s * 1237 + t * 311 + 5);
  endfunction
  function automatic logic [DW-1:0] opB(int s, int t);
    return DW'(s * 97 + t * 4099 + 3);
  endfunction
  function automatic logic [TW-1:0] tagOf(int s, int t);
    return TW'(s * 3 + t);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic driveStep(int s, logic [N-1:0] mask);
    @(negedge clk);
    reqValid = mask;
    for (int t = 0; t < N; t++) begin
      reqOpA[t*DW +: DW] = opA(s, t);
      reqOpB[t*DW +: DW] = opB(s, t);
      reqTag[t*TW +: TW] = tagOf(s, t);
    end
    #5;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    reqValid = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  bit          eV [NV+L];
  int          eT [NV+L];
  logic [TW-1:0]   eTag [NV+L];
  logic [2*DW-1:0] eD [NV+L];

  initial begin
    doReset();
    #5;
    // R1: after reset no result, no grant without requests
    check(resValid == 1'b0, "R1 resValid after reset", resValid, 0);
    check(grant == '0, "R2 idle grant", grant, 0);

    // Table walk: R3, R4, R5, R6, R7, R9
    for (int s = 0; s < NV + L; s++) begin
      logic [N-1:0] mask;
      int ew;
      mask = (s < NV) ? VEC[s][7:0] : '0;
      ew   = (s < NV) ? int'(VEC[s][11:8]) : NONE;
      driveStep(s, mask);
      check(grant == ((ew == NONE) ? N'(0) : N'(1) << ew),
            "R3 R4 rotating grant", grant, (ew == NONE) ? 0 : (1 << ew));
      eV[s] = (ew != NONE);
      eT[s] = ew;
      eTag[s] = (ew != NONE) ? tagOf(s, ew) : '0;
      eD[s] = (ew != NONE) ? (2*DW)'(opA(s, ew)) * (2*DW)'(opB(s, ew)) : '0;
      if (s >= L) begin
        int p;
        p = s - L;
        check(resValid == eV[p], "R5 R9 resValid timing", resValid, eV[p]);
        if (eV[p]) begin
          check(resData == eD[p], "R5 product", resData, eD[p]);
          check(int'(resThread) == eT[p], "R6 thread index", resThread, eT[p]);
          check(resTag == eTag[p], "R6 tag", resTag, eTag[p]);
        end
      end
    end

    // R1: reset returns the pointer to thread 0
    doReset();
    driveStep(0, 8'h81);
    check(grant == 8'h01, "R1 pointer at 0 after reset", grant, 8'h01);

    // R8: a full burst grants every thread once in N cycles
    doReset();
    begin
      logic [N-1:0] seen;
      int dup;
      seen = '0;
      dup = 0;
      for (int s = 0; s < N; s++) begin
        driveStep(s, '1);
        if ((seen & grant) != '0) dup++;
        seen |= grant;
      end
      check(seen == '1, "R8 all threads served", seen, 8'hFF);
      check(dup == 0, "R8 no repeat grant", dup, 0);
    end
    // R7: back-to-back results, grant order 0,1,2..
    driveStep(0, '0);
    check(resValid && resThread == IW'(N - 2), "R7 consecutive results", resThread, N - 2);
    driveStep(0, '0);
    check(resValid && resThread == IW'(N - 1), "R7 consecutive results", resThread, N - 1);
    driveStep(0, '0);
    check(!resValid, "R9 drain", resValid, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule